// File: doc/BRIEF.md
# Mixer Volume Register Remapper

This block holds the volume registers that a host programs through an indirect register file. It decides which physical register receives each write. There are two address spaces. The legacy space has two volume indices: 18 is the left channel and 19 is the right. The extended space has eight registers. Extended register 4 holds a control byte. One bit of that byte asks for the legacy pair to be steered onto the internal synthesizer volume. An input pin says whether the internal synthesizer is enabled at all.

The steering applies only when the pin and the stored bit are both 1. In that case a write to legacy index 18 goes to extended register 6 and a write to index 19 goes to extended register 7. The line input volume then comes from extended registers 0 and 1. Otherwise the legacy indices keep their own storage, and that storage drives the line input volume. Reads of 18 and 19 follow the same steering. The block exposes the effective line input pair, the legacy pair and the synthesizer pair as plain outputs.

Writes come in on a valid/ready port. Ready is held high at all times, so a write is taken on every cycle in which valid is 1 and there is never any back-pressure. The read port is combinational and has no handshake.

Top module: `vol_remap_top`

## Requirements
- R1: After reset every register is 0: all six volume outputs read 0, extended register 4 reads 0, and the steering is off.
- R2: While steering is on (synth_en=1 and bit 0 of extended register 4 is 1), a write to legacy index 18 updates extended register 6 (syn_l) on the next edge and leaves leg_l unchanged.
- R3: While steering is on, a write to legacy index 19 updates extended register 7 (syn_r) and leaves leg_r unchanged.
- R4: While steering is off, which includes the case where only one of the two enables is 1, writes to indices 18 and 19 update leg_l and leg_r, and syn_l and syn_r keep their values.
- R5: Extended registers 0 to 7 (wr_ext=1, wr_idx 0 to 7) are always written directly, whatever the steering state. Each one reads back what was written.
- R6: line_l and line_r equal extended registers 0 and 1 while steering is on, and equal leg_l and leg_r while it is off.
- R7: A read of legacy index 18 or 19 returns the register that a write to that index would update at that moment.
- R8: A write to extended register 4 changes the steering from the next write onward. A write in the very next cycle already follows the new value.
- R9: A write to any other legacy index, or to an extended index of 8 or more, changes no register. A read of such an index returns 0.
- R10: wr_ready is 1 in every cycle, and a write is taken exactly when wr_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| synth_en | input | 1 | Internal synthesizer enable |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted; held at 1 |
| wr_ext | input | 1 | 1 selects the extended space, 0 the legacy space |
| wr_idx | input | 5 | Write index |
| wr_data | input | 8 | Write data |
| rd_ext | input | 1 | Read space select |
| rd_idx | input | 5 | Read index |
| rd_data | output | 8 | Read data, combinational |
| line_l | output | 8 | Effective line input volume, left |
| line_r | output | 8 | Effective line input volume, right |
| leg_l | output | 8 | Legacy index 18 storage |
| leg_r | output | 8 | Legacy index 19 storage |
| syn_l | output | 8 | Synthesizer volume, left (extended 6) |
| syn_r | output | 8 | Synthesizer volume, right (extended 7) |

## Verification
The bench turns on only one of the two enables at a time. A design that steered on either bit alone would corrupt the synthesizer volume at that point. It writes the control register and then, in the very next cycle, a legacy index. A design that registered the steering decision once more would send that write to the old target. It also reads 18 and 19 while steering is on and again after it is cleared. A read mux that ignored the steering would return stale legacy values. Finally it writes indices that have no register and confirms that every output stays the same.

// File: rtl/vol_remap_pkg.sv
package vol_remap_pkg;
  localparam int unsigned DW  = 8;
  localparam int unsigned LIW = 5;
  localparam int unsigned XIW = 3;
  localparam int unsigned XN  = 1 << XIW;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_LEG_L = 2'd1,
    TGT_LEG_R = 2'd2,
    TGT_EXT   = 2'd3
  } tgt_kind_e;

  typedef struct packed {
    tgt_kind_e        kind;
    logic [XIW-1:0]   xi;
  } tgt_t;
endpackage

// File: rtl/vol_remap_route.sv
module vol_remap_route
  import vol_remap_pkg::*;
#(
  parameter int unsigned LEG_L_IDX  = 18,
  parameter int unsigned LEG_R_IDX  = 19,
  parameter int unsigned SYN_L_XIDX = 6,
  parameter int unsigned SYN_R_XIDX = 7
) (
  input  logic           remap_on,
  input  logic           is_ext,
  input  logic [LIW-1:0] idx,
  output tgt_t           tgt
);
  localparam logic [LIW-1:0] LL = LIW'(LEG_L_IDX);
  localparam logic [LIW-1:0] LR = LIW'(LEG_R_IDX);
  localparam logic [XIW-1:0] SL = XIW'(SYN_L_XIDX);
  localparam logic [XIW-1:0] SR = XIW'(SYN_R_XIDX);

  always_comb begin
    tgt.kind = TGT_NONE;
    tgt.xi   = '0;
    if (is_ext) begin
      if (idx[LIW-1:XIW] == '0) begin
        tgt.kind = TGT_EXT;
        tgt.xi   = idx[XIW-1:0];
      end
    end else if (idx == LL) begin
      if (remap_on) begin
        tgt.kind = TGT_EXT;
        tgt.xi   = SL;
      end else begin
        tgt.kind = TGT_LEG_L;
      end
    end else if (idx == LR) begin
      if (remap_on) begin
        tgt.kind = TGT_EXT;
        tgt.xi   = SR;
      end else begin
        tgt.kind = TGT_LEG_R;
      end
    end
  end
endmodule

// File: rtl/vol_remap_bank.sv
module vol_remap_bank
  import vol_remap_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  tgt_t          wtgt,
  input  logic [DW-1:0] wdata,
  input  tgt_t          rtgt,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] ext_q [XN],
  output logic [DW-1:0] leg_l_q,
  output logic [DW-1:0] leg_r_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      leg_l_q <= '0;
      leg_r_q <= '0;
    end else if (we) begin
      if (wtgt.kind == TGT_LEG_L) leg_l_q <= wdata;
      if (wtgt.kind == TGT_LEG_R) leg_r_q <= wdata;
    end
  end

  for (genvar g = 0; g < XN; g++) begin : g_ext
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ext_q[g] <= '0;
      end else if (we && wtgt.kind == TGT_EXT && wtgt.xi == XIW'(g)) begin
        ext_q[g] <= wdata;
      end
    end
  end

  always_comb begin
    unique case (rtgt.kind)
      TGT_LEG_L: rdata = leg_l_q;
      TGT_LEG_R: rdata = leg_r_q;
      TGT_EXT:   rdata = ext_q[rtgt.xi];
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/vol_remap_top.sv
module vol_remap_top
  import vol_remap_pkg::*;
#(
  parameter int unsigned LEG_L_IDX   = 18,
  parameter int unsigned LEG_R_IDX   = 19,
  parameter int unsigned CTL_XIDX    = 4,
  parameter int unsigned REMAP_BIT   = 0,
  parameter int unsigned LINE_L_XIDX = 0,
  parameter int unsigned LINE_R_XIDX = 1,
  parameter int unsigned SYN_L_XIDX  = 6,
  parameter int unsigned SYN_R_XIDX  = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           synth_en,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic           wr_ext,
  input  logic [LIW-1:0] wr_idx,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_ext,
  input  logic [LIW-1:0] rd_idx,
  output logic [DW-1:0]  rd_data,
  output logic [DW-1:0]  line_l,
  output logic [DW-1:0]  line_r,
  output logic [DW-1:0]  leg_l,
  output logic [DW-1:0]  leg_r,
  output logic [DW-1:0]  syn_l,
  output logic [DW-1:0]  syn_r
);
  localparam logic [LIW-1:0] LL = LIW'(LEG_L_IDX);
  localparam logic [LIW-1:0] LR = LIW'(LEG_R_IDX);

  logic          remap_on;
  logic          wr_fire;
  tgt_t          wtgt;
  tgt_t          rtgt;
  logic [DW-1:0] ext_q [XN];

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid & wr_ready;
  assign remap_on = synth_en & ext_q[CTL_XIDX][REMAP_BIT];

  vol_remap_route #(
    .LEG_L_IDX(LEG_L_IDX), .LEG_R_IDX(LEG_R_IDX),
    .SYN_L_XIDX(SYN_L_XIDX), .SYN_R_XIDX(SYN_R_XIDX)
  ) u_wroute (
    .remap_on(remap_on), .is_ext(wr_ext), .idx(wr_idx), .tgt(wtgt)
  );

  vol_remap_route #(
    .LEG_L_IDX(LEG_L_IDX), .LEG_R_IDX(LEG_R_IDX),
    .SYN_L_XIDX(SYN_L_XIDX), .SYN_R_XIDX(SYN_R_XIDX)
  ) u_rroute (
    .remap_on(remap_on), .is_ext(rd_ext), .idx(rd_idx), .tgt(rtgt)
  );

  vol_remap_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .we(wr_fire), .wtgt(wtgt), .wdata(wr_data),
    .rtgt(rtgt), .rdata(rd_data),
    .ext_q(ext_q), .leg_l_q(leg_l), .leg_r_q(leg_r)
  );

  assign syn_l  = ext_q[SYN_L_XIDX];
  assign syn_r  = ext_q[SYN_R_XIDX];
  assign line_l = remap_on ? ext_q[LINE_L_XIDX] : leg_l;
  assign line_r = remap_on ? ext_q[LINE_R_XIDX] : leg_r;

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (line_l == '0 && line_r == '0 && syn_l == '0 && syn_r == '0 && !remap_on));

  // R2
  remap_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && remap_on && !wr_ext && wr_idx == LL) |=> (syn_l == $past(wr_data)) && $stable(leg_l));

  // R3
  remap_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && remap_on && !wr_ext && wr_idx == LR) |=> (syn_r == $past(wr_data)) && $stable(leg_r));

  // R4
  legacy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !remap_on && !wr_ext && wr_idx == LL) |=> (leg_l == $past(wr_data)) && $stable(syn_l));

  // R5
  direct_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_ext && wr_idx == LIW'(SYN_R_XIDX)) |=> (syn_r == $past(wr_data)));

  // R8
  ctl_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_ext && wr_idx == LIW'(CTL_XIDX)) |=> (remap_on == ($past(wr_data[REMAP_BIT]) && synth_en)));

  // R9
  ignored_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wr_ext && wr_idx != LL && wr_idx != LR)
      |=> ($stable(leg_l) && $stable(leg_r) && $stable(syn_l) && $stable(syn_r)));
endmodule

// File: tb/vol_remap_top_tb_top.sv
module vol_remap_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       synth_en = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic       wr_ext = 1'b0;
  logic [4:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic       rd_ext = 1'b0;
  logic [4:0] rd_idx = '0;
  logic [7:0] rd_data, line_l, line_r, leg_l, leg_r, syn_l, syn_r;

  int n_chk = 0;
  int n_err = 0;
  logic probe = 1'b0;
  logic done = 1'b0;

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  vol_remap_top dut_i (
    .clk(clk), .rst_n(rst_n), .synth_en(synth_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_ext(wr_ext),
    .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_ext(rd_ext), .rd_idx(rd_idx), .rd_data(rd_data),
    .line_l(line_l), .line_r(line_r), .leg_l(leg_l), .leg_r(leg_r),
    .syn_l(syn_l), .syn_r(syn_r)
  );

  function automatic logic [7:0] pick(int sel);
    case (sel)
      0: return line_l;
      1: return line_r;
      2: return leg_l;
      3: return leg_r;
      4: return syn_l;
      5: return syn_r;
      6: return rd_data;
      default: return {7'd0, wr_ready};
    endcase
  endfunction

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (probe) begin
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb_q.pop_front();
        act = pick(it.sel);
        n_chk++;
        if (act !== it.exp) begin
          n_err++;
          $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_v(int sel, logic [7:0] v, string tag);
    item_t it;
    it.sel = sel; it.exp = v; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic flush();
    @(posedge clk); #1 probe = 1'b1;
    @(posedge clk); #1 probe = 1'b0;
  endtask

  task automatic rd_chk(logic e, logic [4:0] i, logic [7:0] v, string tag);
    rd_ext = e; rd_idx = i;
    expect_v(6, v, tag);
    flush();
  endtask

  task automatic wr(logic e, logic [4:0] i, logic [7:0] d);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_ext = e; wr_idx = i; wr_data = d;
    @(posedge clk); #1 wr_valid = 1'b0;
  endtask

  task automatic wr2(logic e0, logic [4:0] i0, logic [7:0] d0,
                     logic e1, logic [4:0] i1, logic [7:0] d1);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_ext = e0; wr_idx = i0; wr_data = d0;
    @(posedge clk); #1;
    wr_ext = e1; wr_idx = i1; wr_data = d1;
    @(posedge clk); #1 wr_valid = 1'b0;
  endtask

  task automatic outs(logic [7:0] ll, logic [7:0] lr, logic [7:0] gl,
                      logic [7:0] gr, logic [7:0] sl, logic [7:0] sr, string tag);
    expect_v(0, ll, {tag, " line_l"});
    expect_v(1, lr, {tag, " line_r"});
    expect_v(2, gl, {tag, " leg_l"});
    expect_v(3, gr, {tag, " leg_r"});
    expect_v(4, sl, {tag, " syn_l"});
    expect_v(5, sr, {tag, " syn_r"});
    flush();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    outs(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R1");
    rd_chk(1'b1, 5'd4, 8'h00, "R1 ctl");
    // R10 ready
    expect_v(7, 8'h01, "R10 ready");
    flush();

    // R4 steering off: legacy storage
    wr(1'b0, 5'd18, 8'h11);
    wr(1'b0, 5'd19, 8'h22);
    outs(8'h11, 8'h22, 8'h11, 8'h22, 8'h00, 8'h00, "R4 R6 off");
    rd_chk(1'b0, 5'd18, 8'h11, "R7 off");

    // R5 direct extended writes
    wr(1'b1, 5'd0, 8'h30);
    wr(1'b1, 5'd1, 8'h31);
    wr(1'b1, 5'd6, 8'h60);
    wr(1'b1, 5'd7, 8'h70);
    outs(8'h11, 8'h22, 8'h11, 8'h22, 8'h60, 8'h70, "R5");
    rd_chk(1'b1, 5'd0, 8'h30, "R5 rd0");
    rd_chk(1'b1, 5'd1, 8'h31, "R5 rd1");

    // R4 only remap bit set, synth disabled
    wr(1'b1, 5'd4, 8'h05);
    wr(1'b0, 5'd18, 8'h33);
    outs(8'h33, 8'h22, 8'h33, 8'h22, 8'h60, 8'h70, "R4 half");
    rd_chk(1'b1, 5'd4, 8'h05, "R5 ctl");

    // steering on
    synth_en = 1'b1;
    outs(8'h30, 8'h31, 8'h33, 8'h22, 8'h60, 8'h70, "R6 on");
    rd_chk(1'b0, 5'd18, 8'h60, "R7 on L");
    rd_chk(1'b0, 5'd19, 8'h70, "R7 on R");
    wr(1'b0, 5'd18, 8'h44);
    outs(8'h30, 8'h31, 8'h33, 8'h22, 8'h44, 8'h70, "R2");
    wr(1'b0, 5'd19, 8'h55);
    outs(8'h30, 8'h31, 8'h33, 8'h22, 8'h44, 8'h55, "R3");
    rd_chk(1'b0, 5'd18, 8'h44, "R7 after");

    // R8 back-to-back control then legacy
    wr2(1'b1, 5'd4, 8'h00, 1'b0, 5'd18, 8'h66);
    outs(8'h66, 8'h22, 8'h66, 8'h22, 8'h44, 8'h55, "R8 clear");
    wr2(1'b1, 5'd4, 8'h01, 1'b0, 5'd19, 8'h77);
    outs(8'h30, 8'h31, 8'h66, 8'h22, 8'h44, 8'h77, "R8 set");

    // R9 ignored indices
    wr(1'b0, 5'd5, 8'hAA);
    wr(1'b1, 5'd12, 8'hBB);
    outs(8'h30, 8'h31, 8'h66, 8'h22, 8'h44, 8'h77, "R9");
    rd_chk(1'b0, 5'd5, 8'h00, "R9 rd leg");
    rd_chk(1'b1, 5'd12, 8'h00, "R9 rd ext");

    // R7 read follows when synth enable drops
    synth_en = 1'b0;
    rd_chk(1'b0, 5'd19, 8'h22, "R7 drop");
    outs(8'h66, 8'h22, 8'h66, 8'h22, 8'h44, 8'h77, "R6 drop");
    expect_v(7, 8'h01, "R10 end");
    flush();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule